// File: doc/BRIEF.md
# Paged Two-Wire Management Register Target

This block is a two-wire serial target that gives a host controller byte access to a module's management registers. Bus clock and data come in as plain line levels. The target pulls the data line low through an open-drain enable and never drives the clock line. An active-low select input decides whether the target takes part on the bus at all. Many modules can therefore share one bus address, and the host picks one module at a time.

The host sees a 256-byte window. Bytes 0 to 127 are one fixed lower page. Byte 127 holds the page-select value, and it picks which upper page appears at bytes 128 to 255. Upper pages 0 and 3 are always present. Pages 1 and 2 exist only when a build parameter enables them.

A number of two-byte monitor fields are placed in the lower page. Each field is big-endian, and its value comes from outside the block. Reading a field's high byte captures the whole field, so a two-byte read always returns a matched pair. Each byte sent to the host produces a one-cycle strobe that carries the byte address and the current page. A neighbouring flag block uses this strobe to clear its latched flags when they are read.

The protocol state machine has eight states:

- `ST_IDLE`: waits for a start condition.
- `ST_DEVADR`: shifts in the address byte. It moves to `ST_DEVACK` on a match, or back to `ST_IDLE` if the address does not match.
- `ST_DEVACK`: drives the acknowledge bit. It then goes to `ST_RDATA` for a read or to `ST_OFFSET` for a write.
- `ST_OFFSET`: receives the register pointer, then moves to `ST_RXACK`.
- `ST_WDATA`: receives a data byte, then moves to `ST_RXACK`.
- `ST_RXACK`: acknowledges the received byte, then moves to `ST_WDATA`.
- `ST_RDATA`: sends a byte, then moves to `ST_RDACK`.
- `ST_RDACK`: samples the host's acknowledge. An acknowledge returns to `ST_RDATA`; a not-acknowledge goes to `ST_IDLE`.

Three events override any state. Deselect and a stop condition both force `ST_IDLE`. A start condition, including a repeated start, forces `ST_DEVADR`.

Top module: `mgmt_twi_target`

## Requirements
- R1: After reset, the SDA pull-down is off, the read strobe is low, the page-select byte (127) reads 0, and every writable byte reads 0.
- R2: The target acknowledges only the 7-bit address 1010000, seen as byte 0xA0 for a write or 0xA1 for a read. It acknowledges by pulling SDA low during the ninth clock. For any other address it leaves SDA released.
- R3: While the synchronized select input is high, the target acknowledges nothing, including its own address, and never pulls SDA low.
- R4: In a write, the first byte after the address is loaded into the register pointer. Each following byte is stored at the pointer, after which the pointer advances. The target acknowledges every byte.
- R5: A read that follows a repeated start returns bytes MSB first, starting at the pointer and advancing after each byte. When the host answers a byte with a not-acknowledge, the target releases SDA and goes idle.
- R6: Writing byte 127 selects the upper page. Values 0 and 3 are always accepted. Values 1 and 2 are accepted only when HAS_OPT_PAGES is 1. Any other value leaves the page unchanged. Each upper page keeps its own 128 bytes.
- R7: When the pointer advances, 255 wraps to 128 and 127 moves on to 128. All other values simply add one.
- R8: Monitor field k sits at byte MON_BASE+2k (high byte) and MON_BASE+2k+1 (low byte), taken from mon_data_i[16k+15:16k]. Reading the high byte captures all 16 bits, and the low byte returns the captured value. Writes to monitor bytes are ignored.
- R9: For each byte loaded for transmission, rd_stb_o pulses high for exactly one cycle, with rd_addr_o equal to that byte's address and rd_page_o equal to the current page. Writes produce no strobe.
- R10: A pulse on SCL or SDA shorter than 3 system clocks has no effect. A false start made this way is not treated as a start, and a short SCL glitch does not count as a bit.
- R11: If select goes high in the middle of a transfer, SDA is released within 3 system clocks. The target returns to idle and waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sel_n_i | input | 1 | Active-low module select |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| mon_data_i | input | NUM_MON*16 | Live monitor values, 16 bits per field |
| rd_stb_o | output | 1 | One-cycle pulse per byte loaded for transmission |
| rd_addr_o | output | 8 | Byte address belonging to the strobe |
| rd_page_o | output | 8 | Page select in effect at the strobe |

## Verification
Both bus lines pass through two synchronizer flops and a three-cycle filter, and the state machine adds one register. An acknowledge or data bit therefore reaches sda_pull_o about six system clocks after SCL falls. The bench samples SDA midway through the following SCL high phase, roughly thirty clocks after the fall, so the result has long settled. The read strobe comes one cycle after the target loads the byte. The bench counts strobes on falling clock edges and checks the count and the last address once the host's stop has completed. A deselect reaches the pull-down after two synchronizer flops plus one register. The bench checks the released line four clocks after raising select.

// File: rtl/mgmt_twi_pkg.sv
package mgmt_twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_OFFSET,
        ST_RXACK,
        ST_WDATA,
        ST_RDATA,
        ST_RDACK
    } twi_state_e;

    localparam logic [7:0] PAGE_SEL_ADDR = 8'd127;

    // pointer advance: upper half wraps inside itself, lower half runs into the upper half
    function automatic logic [7:0] ptr_next(input logic [7:0] p);
        return (p == 8'hFF) ? 8'h80 : p + 8'd1;
    endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            run_q  <= '0;
            line_o <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            if (sync_q != line_o) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    line_o <= sync_q;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    // R10: the filtered level only ever moves to a value the synchronizer already held
    p_filter_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(sync_q) == line_o));

endmodule

// File: rtl/mgmt_page_regs.sv
module mgmt_page_regs
    import mgmt_twi_pkg::*;
#(
    parameter int HAS_OPT_PAGES = 1,
    parameter int NUM_MON       = 2,
    parameter int MON_BASE      = 22
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [7:0]             rd_addr,
    input  logic                   rd_take,
    input  logic [NUM_MON*16-1:0]  mon_data,
    output logic [7:0]             rd_data,
    output logic [7:0]             page_o
);
    localparam int NUM_UP = (HAS_OPT_PAGES != 0) ? 4 : 2;
    localparam int UP_AW  = $clog2(NUM_UP * 128);

    logic [7:0]  low_mem [128];
    logic [7:0]  up_mem  [NUM_UP*128];
    logic [7:0]  page_q;
    logic [15:0] snap_q  [NUM_MON];

    function automatic logic page_ok(input logic [7:0] p);
        return (p == 8'd0) || (p == 8'd3) ||
               ((HAS_OPT_PAGES != 0) && (p == 8'd1 || p == 8'd2));
    endfunction

    function automatic logic [UP_AW-1:0] up_addr(input logic [7:0] pg, input logic [6:0] a);
        logic [1:0] ix;
        ix = (HAS_OPT_PAGES != 0) ? pg[1:0] : {1'b0, pg[1]};
        return UP_AW'({ix, a});
    endfunction

    function automatic logic mon_hit(input logic [7:0] a);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NUM_MON; k++) begin
            if (a == 8'(MON_BASE + 2*k) || a == 8'(MON_BASE + 2*k + 1)) hit = 1'b1;
        end
        return hit;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= 8'd0;
            for (int i = 0; i < 128; i++) low_mem[i] <= 8'd0;
            for (int i = 0; i < NUM_UP*128; i++) up_mem[i] <= 8'd0;
        end else if (wr_en) begin
            if (wr_addr == PAGE_SEL_ADDR) begin
                if (page_ok(wr_data)) page_q <= wr_data;
            end else if (wr_addr[7]) begin
                up_mem[up_addr(page_q, wr_addr[6:0])] <= wr_data;
            end else if (!mon_hit(wr_addr)) begin
                low_mem[wr_addr[6:0]] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_MON; k++) snap_q[k] <= 16'd0;
        end else if (rd_take) begin
            for (int k = 0; k < NUM_MON; k++) begin
                if (rd_addr == 8'(MON_BASE + 2*k)) snap_q[k] <= mon_data[16*k +: 16];
            end
        end
    end

    always_comb begin
        if (rd_addr == PAGE_SEL_ADDR) begin
            rd_data = page_q;
        end else if (rd_addr[7]) begin
            rd_data = up_mem[up_addr(page_q, rd_addr[6:0])];
        end else begin
            rd_data = low_mem[rd_addr[6:0]];
            for (int k = 0; k < NUM_MON; k++) begin
                if (rd_addr == 8'(MON_BASE + 2*k))     rd_data = mon_data[16*k+8 +: 8];
                if (rd_addr == 8'(MON_BASE + 2*k + 1)) rd_data = snap_q[k][7:0];
            end
        end
    end

    assign page_o = page_q;

    p_page_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        page_ok(page_q));

    p_snap_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && rd_addr == 8'(MON_BASE)) |=> (snap_q[0] == $past(mon_data[15:0])));

endmodule

// File: rtl/twi_bus_fsm.sv
module twi_bus_fsm
    import mgmt_twi_pkg::*;
#(
    parameter logic [6:0] TWI_ADDR = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic       desel,
    input  logic [7:0] rd_data,
    input  logic [7:0] page_i,
    output logic       sda_pull,
    output logic [7:0] ptr_o,
    output logic       take_o,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       rd_stb,
    output logic [7:0] rd_addr,
    output logic [7:0] rd_page
);
    twi_state_e st, nxt;

    logic       scl_d, sda_d;
    logic [3:0] cnt;
    logic [7:0] shreg, tx;
    logic       rw, mack;
    logic [7:0] ptr;

    wire scl_rise = scl & ~scl_d;
    wire scl_fall = ~scl & scl_d;
    wire start_ev = scl & scl_d & sda_d & ~sda;
    wire stop_ev  = scl & scl_d & ~sda_d & sda;
    wire take     = ~desel & ~start_ev & ~stop_ev & scl_fall &
                    (((st == ST_DEVACK) & rw) | ((st == ST_RDACK) & mack));

    always_comb begin
        nxt = st;
        if (desel)         nxt = ST_IDLE;
        else if (start_ev) nxt = ST_DEVADR;
        else if (stop_ev)  nxt = ST_IDLE;
        else if (scl_fall) begin
            unique case (st)
                ST_IDLE:   nxt = ST_IDLE;
                ST_DEVADR: if (cnt == 4'd8) nxt = (shreg[7:1] == TWI_ADDR) ? ST_DEVACK : ST_IDLE;
                ST_DEVACK: nxt = rw ? ST_RDATA : ST_OFFSET;
                ST_OFFSET: if (cnt == 4'd8) nxt = ST_RXACK;
                ST_WDATA:  if (cnt == 4'd8) nxt = ST_RXACK;
                ST_RXACK:  nxt = ST_WDATA;
                ST_RDATA:  if (cnt == 4'd8) nxt = ST_RDACK;
                ST_RDACK:  nxt = mack ? ST_RDATA : ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1; sda_d <= 1'b1; cnt <= '0; shreg <= '0; tx <= '0;
            rw <= 1'b0; mack <= 1'b0; ptr <= '0; sda_pull <= 1'b0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
            rd_stb <= 1'b0; rd_addr <= '0; rd_page <= '0;
        end else begin
            scl_d  <= scl;
            sda_d  <= sda;
            wr_en  <= 1'b0;
            rd_stb <= take;
            if (take) begin
                rd_addr  <= ptr;
                rd_page  <= page_i;
                sda_pull <= ~rd_data[7];
                tx       <= {rd_data[6:0], 1'b0};
                cnt      <= 4'd1;
                ptr      <= ptr_next(ptr);
            end else if (desel || start_ev || stop_ev) begin
                sda_pull <= 1'b0;
                cnt      <= '0;
            end else if (scl_rise) begin
                if ((st == ST_DEVADR || st == ST_OFFSET || st == ST_WDATA) && cnt < 4'd8) begin
                    shreg <= {shreg[6:0], sda};
                    cnt   <= cnt + 4'd1;
                end
                if (st == ST_RDACK) mack <= ~sda;
            end else if (scl_fall) begin
                unique case (st)
                    ST_IDLE: ;
                    ST_DEVADR: if (cnt == 4'd8 && shreg[7:1] == TWI_ADDR) begin
                        sda_pull <= 1'b1;
                        rw       <= shreg[0];
                    end
                    ST_DEVACK: begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                    end
                    ST_OFFSET: if (cnt == 4'd8) begin
                        ptr      <= shreg;
                        sda_pull <= 1'b1;
                    end
                    ST_WDATA: if (cnt == 4'd8) begin
                        wr_en    <= 1'b1;
                        wr_addr  <= ptr;
                        wr_data  <= shreg;
                        ptr      <= ptr_next(ptr);
                        sda_pull <= 1'b1;
                    end
                    ST_RXACK: begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                    end
                    ST_RDATA: if (cnt < 4'd8) begin
                        sda_pull <= ~tx[7];
                        tx       <= {tx[6:0], 1'b0};
                        cnt      <= cnt + 4'd1;
                    end else begin
                        sda_pull <= 1'b0;
                    end
                    ST_RDACK: sda_pull <= 1'b0;
                endcase
            end
        end
    end

    assign ptr_o  = ptr;
    assign take_o = take;

    p_desel_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !sda_pull);

    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_pull);

    p_wrap_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == 8'hFF) |-> (ptr == 8'h80));

    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

endmodule

// File: rtl/mgmt_twi_target.sv
module mgmt_twi_target #(
    parameter logic [6:0] TWI_ADDR      = 7'h50,
    parameter int         FILT_LEN      = 3,
    parameter int         HAS_OPT_PAGES = 1,
    parameter int         NUM_MON       = 2,
    parameter int         MON_BASE      = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  sel_n_i,
    output logic                  sda_pull_o,
    input  logic [NUM_MON*16-1:0] mon_data_i,
    output logic                  rd_stb_o,
    output logic [7:0]            rd_addr_o,
    output logic [7:0]            rd_page_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, clean_lines;
    logic              sel_meta, sel_sync;
    logic [7:0]        ptr, rd_data, page;
    logic              take, wr_en;
    logic [7:0]        wr_addr, wr_data;

    assign raw_lines = {sda_i, scl_i};

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        twi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[i]),
            .line_o (clean_lines[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_meta <= 1'b1;
            sel_sync <= 1'b1;
        end else begin
            sel_meta <= sel_n_i;
            sel_sync <= sel_meta;
        end
    end

    twi_bus_fsm #(.TWI_ADDR(TWI_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_lines[0]),
        .sda      (clean_lines[1]),
        .desel    (sel_sync),
        .rd_data  (rd_data),
        .page_i   (page),
        .sda_pull (sda_pull_o),
        .ptr_o    (ptr),
        .take_o   (take),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb_o),
        .rd_addr  (rd_addr_o),
        .rd_page  (rd_page_o)
    );

    mgmt_page_regs #(
        .HAS_OPT_PAGES (HAS_OPT_PAGES),
        .NUM_MON       (NUM_MON),
        .MON_BASE      (MON_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .rd_take  (take),
        .mon_data (mon_data_i),
        .rd_data  (rd_data),
        .page_o   (page)
    );

endmodule

// File: tb/mgmt_twi_target_tb_top.sv
`timescale 1ns/1ps
module mgmt_twi_target_tb_top;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_pull = 1'b0;
    logic        sel_n = 1'b0;
    logic [31:0] mon = 32'h1234_5678;
    logic        sda_pull_o, rd_stb_o;
    logic [7:0]  rd_addr_o, rd_page_o;
    logic        sda_line;
    bit          scl_glitch = 1'b0;
    bit          done = 1'b0;

    int checks = 0, errors = 0, stb_cnt = 0;
    logic [7:0] last_addr = 8'h00, last_page = 8'h00;
    logic [7:0] exp_low [128];
    logic [7:0] exp_up  [4][128];
    logic [7:0] cur_page = 8'h00;

    assign sda_line = !(m_pull || sda_pull_o);

    always #4 clk = ~clk;

    mgmt_twi_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sel_n_i(sel_n),
        .sda_pull_o(sda_pull_o), .mon_data_i(mon), .rd_stb_o(rd_stb_o),
        .rd_addr_o(rd_addr_o), .rd_page_o(rd_page_o)
    );

    always @(negedge clk) if (rd_stb_o) begin
        stb_cnt++;
        last_addr = rd_addr_o;
        last_page = rd_page_o;
    end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] nx(input logic [7:0] a);
        return (a == 8'hFF) ? 8'h80 : a + 8'd1;
    endfunction

    function automatic logic [7:0] gen(input logic [7:0] a, input logic [7:0] p);
        return 8'((a * 7) + (p * 61) + 3);
    endfunction

    function automatic logic [7:0] exp_at(input logic [7:0] a);
        if (a == 8'd127) return cur_page;
        if (a[7])        return exp_up[cur_page[1:0]][a[6:0]];
        return exp_low[a[6:0]];
    endfunction

    task automatic i2c_start; tick(H); m_pull = 1'b1; tick(H); m_scl = 1'b0; tick(5); endtask
    task automatic i2c_rstart;
        m_pull = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_pull = 1'b1; tick(H); m_scl = 1'b0; tick(5);
    endtask
    task automatic i2c_stop; m_pull = 1'b1; tick(H); m_scl = 1'b1; tick(H); m_pull = 1'b0; tick(H); endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_pull = !b[i];
            tick(H); m_scl = 1'b1;
            if (scl_glitch) begin tick(H/2); m_scl = 1'b0; tick(2); m_scl = 1'b1; tick(H/2 - 2); end
            else tick(H);
            m_scl = 1'b0; tick(5);
        end
        m_pull = 1'b0; tick(H); m_scl = 1'b1; tick(H/2);
        acked = !sda_line;
        tick(H/2); m_scl = 1'b0; tick(5);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b);
        m_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(H); m_scl = 1'b1; tick(H/2); b[i] = sda_line; tick(H/2); m_scl = 1'b0; tick(5);
        end
        m_pull = ack; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(5); m_pull = 1'b0;
    endtask

    task automatic write_run(input logic [7:0] off, input int n);
        bit ak; logic [7:0] a; logic [7:0] d; int s0;
        s0 = stb_cnt; a = off;
        i2c_start;
        send_byte(8'hA0, ak); chk(ak, "R2 write address ack", ak, 1);
        send_byte(off, ak);   chk(ak, "R4 offset ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            d = gen(a, cur_page);
            send_byte(d, ak); chk(ak, "R4 data ack", ak, 1);
            if (a[7]) exp_up[cur_page[1:0]][a[6:0]] = d; else exp_low[a[6:0]] = d;
            a = nx(a);
        end
        i2c_stop;
        chk(stb_cnt == s0, "R9 no strobe on write", stb_cnt, s0);
    endtask

    task automatic write_one(input logic [7:0] addr, input logic [7:0] d);
        bit ak;
        i2c_start;
        send_byte(8'hA0, ak); chk(ak, "R2 address ack", ak, 1);
        send_byte(addr, ak);  chk(ak, "R4 offset ack", ak, 1);
        send_byte(d, ak);     chk(ak, "R4 data ack", ak, 1);
        i2c_stop;
    endtask

    task automatic read_run(input logic [7:0] off, input int n);
        bit ak; logic [7:0] a; logic [7:0] b; logic [7:0] la; int s0;
        s0 = stb_cnt; a = off; la = off;
        i2c_start;
        send_byte(8'hA0, ak); chk(ak, "R2 address ack", ak, 1);
        send_byte(off, ak);   chk(ak, "R4 offset ack", ak, 1);
        i2c_rstart;
        send_byte(8'hA1, ak); chk(ak, "R5 read address ack", ak, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            chk(b == exp_at(a), (a == 8'h80 || a == 8'd127) ? "R7 pointer advance" : "R5 read data", b, exp_at(a));
            la = a; a = nx(a);
        end
        i2c_stop;
        chk(stb_cnt == s0 + n, "R9 strobe count", stb_cnt, s0 + n);
        chk(last_addr == la, "R9 strobe address", last_addr, la);
        chk(last_page == cur_page, "R9 strobe page", last_page, cur_page);
    endtask

    task automatic set_page(input logic [7:0] p);
        write_one(8'd127, p);
        if (p == 8'd0 || p == 8'd1 || p == 8'd2 || p == 8'd3) cur_page = p;
    endtask

    initial begin
        bit ak; logic [7:0] b;
        for (int i = 0; i < 128; i++) begin
            exp_low[i] = 8'h00;
            for (int p = 0; p < 4; p++) exp_up[p][i] = 8'h00;
        end
        tick(6); rst_n = 1'b1; tick(6);
        // R1 reset state
        chk(sda_pull_o == 1'b0, "R1 SDA released", sda_pull_o, 0);
        chk(rd_stb_o == 1'b0, "R1 strobe low", rd_stb_o, 0);
        read_run(8'd126, 3);

        // R2 address sweep
        for (int a = 8'h48; a < 8'h58; a++) begin
            i2c_start;
            send_byte({a[6:0], 1'b0}, ak);
            chk(ak == (a == 8'h50), "R2 address match", ak, a == 8'h50);
            i2c_stop;
        end

        // R3 deselected for a whole transaction
        sel_n = 1'b1; tick(4);
        i2c_start; send_byte(8'hA0, ak); chk(!ak, "R3 no ack when deselected", ak, 0); i2c_stop;
        sel_n = 1'b0; tick(4);

        // R4 and R5 lower page write and read back
        write_run(8'd30, 24);
        read_run(8'd30, 24);

        // R6 and R7 every upper page, wrapping across 255
        for (int p = 0; p < 4; p++) begin set_page(8'(p)); write_run(8'd250, 8); end
        for (int p = 0; p < 4; p++) begin set_page(8'(p)); read_run(8'd250, 8); end
        set_page(8'd3);
        write_one(8'd127, 8'd5);
        read_run(8'd127, 1);
        write_one(8'd127, 8'd200);
        read_run(8'd125, 4);

        // R8 coherent monitor read and write protection
        mon = 32'h1234_5678;
        i2c_start;
        send_byte(8'hA0, ak); send_byte(8'd22, ak);
        i2c_rstart; send_byte(8'hA1, ak);
        recv_byte(1'b1, b); chk(b == 8'h56, "R8 field0 high", b, 8'h56);
        mon = 32'hABCD_EF01;
        recv_byte(1'b1, b); chk(b == 8'h78, "R8 field0 low from capture", b, 8'h78);
        recv_byte(1'b1, b); chk(b == 8'hAB, "R8 field1 high live", b, 8'hAB);
        recv_byte(1'b0, b); chk(b == 8'hCD, "R8 field1 low", b, 8'hCD);
        i2c_stop;
        write_one(8'd24, 8'h00);
        i2c_start;
        send_byte(8'hA0, ak); send_byte(8'd24, ak);
        i2c_rstart; send_byte(8'hA1, ak);
        recv_byte(1'b0, b); chk(b == 8'hAB, "R8 monitor write ignored", b, 8'hAB);
        i2c_stop;

        // R10 short SDA pulse while idle is not a start
        tick(H); m_pull = 1'b1; tick(2); m_pull = 1'b0; tick(H);
        m_scl = 1'b0; tick(5);
        send_byte(8'hA0, ak); chk(!ak, "R10 false start ignored", ak, 0);
        i2c_stop;
        // R10 short SCL glitch does not add a bit
        scl_glitch = 1'b1;
        write_one(8'd70, 8'hC3);
        scl_glitch = 1'b0;
        exp_low[70] = 8'hC3;
        read_run(8'd70, 1);

        // R11 deselect while the target drives data
        write_one(8'd60, 8'h00); exp_low[60] = 8'h00;
        i2c_start;
        send_byte(8'hA0, ak); send_byte(8'd60, ak);
        i2c_rstart; send_byte(8'hA1, ak);
        tick(10);
        chk(sda_pull_o == 1'b1, "R5 target drives bit7 low", sda_pull_o, 1);
        sel_n = 1'b1; tick(4);
        chk(sda_pull_o == 1'b0, "R11 release on deselect", sda_pull_o, 0);
        sel_n = 1'b0; tick(4);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R11 stays idle", b, 8'hFF);
        i2c_stop;
        read_run(8'd60, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule